// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Generator

This block supervises a processor. It drives one active-low reset output that three sources can assert: a supply that has gone out of tolerance, a pushbutton press that has passed a debounce filter, and a watchdog that runs out because the software stopped strobing it. Each source holds the reset for at least a minimum time. After a supply fault, the reset is held for a longer power-up period once the supply is good again. All time windows are counted in ticks of a slow enable input that arrives in the fast clock domain.

The block also gates the chip-enable of a battery-backed SRAM. While the supply flag reports a fault, the gated chip-enable is forced inactive, so a collapsing processor bus cannot write to memory. At all other times it passes the processor's chip-enable through. A separate comparator result is turned into an active-low power-fail warning. The analog comparators and the battery switch are outside the block. Their decisions arrive as digital inputs.

Top module: `sup_reset_wdog`

## Requirements
- R1: While `rst` is high, `rst_n_out` is low. After `rst` falls with `vcc_ok` high and `tick` high every cycle, `rst_n_out` stays low for exactly `HOLD_TICKS` more clock cycles.
- R2: When `vcc_ok` is sampled low at a clock edge, `rst_n_out` is low after that edge and remains low for as long as `vcc_ok` stays low.
- R3: After `vcc_ok` returns high, `rst_n_out` stays low for exactly `HOLD_TICKS` ticks and then goes high. A fault lasting F cycles therefore gives a low pulse of F plus `HOLD_TICKS` cycles when ticks come every cycle.
- R4: A press is `btn_n` held low for at least `DEB_TICKS` ticks after synchronization. It produces exactly one reset pulse of `PULSE_TICKS` ticks, however long the button is held.
- R5: A low glitch on `btn_n` shorter than `DEB_TICKS` ticks causes no reset.
- R6: Releasing the button (`btn_n` going back high) causes no reset.
- R7: If `strobe` has no falling edge, a reset pulse of `PULSE_TICKS` ticks fires each time `WDOG_TICKS` ticks have passed since the last release of the reset. Between pulses, `rst_n_out` is high for exactly `WDOG_TICKS` cycles.
- R8: Falling edges of `strobe` that come closer together than the watchdog period keep `rst_n_out` high indefinitely.
- R9: While `vcc_ok` is low, `ce_out_n` is 1 whatever `ce_in_n` does. While `vcc_ok` is high, `ce_out_n` equals `ce_in_n` within the same cycle.
- R10: `pfail_n` is the inverse of `pf_below`, registered one clock later.
- R11: Reset windows advance only on cycles with `tick` high. While `tick` is low, an active reset does not release, so K tick-less cycles lengthen a pulse by K cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable; every window counts these |
| vcc_ok | input | 1 | Digitized supply-in-tolerance flag (1 = good) |
| btn_n | input | 1 | Raw pushbutton, low when pressed |
| strobe | input | 1 | Watchdog strobe; a falling edge restarts the period |
| ce_in_n | input | 1 | Processor SRAM chip-enable, active low |
| pf_below | input | 1 | Power-fail comparator result, 1 = below threshold |
| rst_n_out | output | 1 | Processor reset, active low |
| ce_out_n | output | 1 | Gated SRAM chip-enable, active low |
| pfail_n | output | 1 | Power-fail warning, active low |

## Verification
The watchdog expiry is the hardest case to reach from the ports. Any strobe activity restarts the period, and every reset release restarts it as well. The bench therefore keeps a background strobe running for all other tests, and only silences it for the watchdog test. It then measures the exact high interval between two consecutive self-inflicted pulses. The tick-freeze case is also hard to reach. It is set up by dropping `tick` on the very sample where a button-driven pulse is first seen, so the lengthened width can be predicted exactly.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_SUPPLY = 2'd1,
        SRC_BUTTON = 2'd2,
        SRC_WDOG   = 2'd3
    } rst_src_e;

    typedef struct packed {
        logic supply_fault;
        logic button_press;
        logic wdog_expire;
    } rst_req_t;

    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Supply fault outranks the short pulse sources
    function automatic rst_src_e pick_source(input rst_req_t r);
        if (r.supply_fault) return SRC_SUPPLY;
        if (r.wdog_expire)  return SRC_WDOG;
        if (r.button_press) return SRC_BUTTON;
        return SRC_NONE;
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int STAGES = 2,
    parameter bit INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{INIT}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
    parameter int DEB_TICKS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw_n,
    output logic press
);
    import sup_pkg::*;

    localparam int W = bits_for(DEB_TICKS);
    localparam logic [W-1:0] LAST = W'(DEB_TICKS - 1);

    logic         pin_n;
    logic         settled_n;
    logic [W-1:0] agree;
    logic         flip;

    sup_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(raw_n), .q(pin_n)
    );

    assign flip  = (pin_n != settled_n) && tick && (agree == LAST);
    assign press = flip && settled_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            settled_n <= 1'b1;
            agree     <= '0;
        end else if (pin_n == settled_n) begin
            agree <= '0;
        end else if (flip) begin
            settled_n <= pin_n;
            agree     <= '0;
        end else if (tick) begin
            agree <= agree + W'(1);
        end
    end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int WDOG_TICKS  = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic strobe,
    input  logic hold,
    output logic expire
);
    import sup_pkg::*;

    localparam int W = bits_for(WDOG_TICKS);
    localparam logic [W-1:0] LAST = W'(WDOG_TICKS - 1);

    logic         stb_s;
    logic         stb_prev;
    logic         kick;
    logic [W-1:0] elapsed;

    sup_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(strobe), .q(stb_s)
    );

    assign kick   = stb_prev && !stb_s;
    assign expire = tick && !hold && !kick && (elapsed == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_prev <= 1'b1;
            elapsed  <= '0;
        end else begin
            stb_prev <= stb_s;
            if (hold || kick || expire) elapsed <= '0;
            else if (tick)              elapsed <= elapsed + W'(1);
        end
    end
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
    parameter int HOLD_TICKS  = 12,
    parameter int PULSE_TICKS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  sup_pkg::rst_req_t req,
    output logic              active
);
    import sup_pkg::*;

    localparam int W = bits_for(max2(HOLD_TICKS, PULSE_TICKS));
    localparam logic [W-1:0] HOLD_V  = W'(HOLD_TICKS);
    localparam logic [W-1:0] PULSE_V = W'(PULSE_TICKS - 1);

    rst_src_e     src;
    logic [W-1:0] remain;

    assign src = pick_source(req);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            remain <= HOLD_V;
        end else begin
            unique case (src)
                SRC_SUPPLY: begin
                    active <= 1'b1;
                    remain <= HOLD_V;
                end
                SRC_BUTTON, SRC_WDOG: begin
                    active <= 1'b1;
                    if (!active || remain < PULSE_V) remain <= PULSE_V;
                end
                default: begin
                    if (active && tick) begin
                        if (remain == '0) active <= 1'b0;
                        else              remain <= remain - W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog #(
    parameter int HOLD_TICKS  = 12,
    parameter int PULSE_TICKS = 6,
    parameter int DEB_TICKS   = 4,
    parameter int WDOG_TICKS  = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic vcc_ok,
    input  logic btn_n,
    input  logic strobe,
    input  logic ce_in_n,
    input  logic pf_below,
    output logic rst_n_out,
    output logic ce_out_n,
    output logic pfail_n
);
    import sup_pkg::*;

    rst_req_t req;
    logic     active;
    logic     press;
    logic     expire;
    logic     warn_q;

    sup_debounce #(.DEB_TICKS(DEB_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_deb (
        .clk(clk), .rst(rst), .tick(tick), .raw_n(btn_n), .press(press)
    );

    sup_wdog #(.WDOG_TICKS(WDOG_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_wdog (
        .clk(clk), .rst(rst), .tick(tick), .strobe(strobe),
        .hold(active), .expire(expire)
    );

    always_comb begin
        req.supply_fault = !vcc_ok;
        req.button_press = press;
        req.wdog_expire  = expire;
    end

    sup_stretch #(.HOLD_TICKS(HOLD_TICKS), .PULSE_TICKS(PULSE_TICKS)) u_str (
        .clk(clk), .rst(rst), .tick(tick), .req(req), .active(active)
    );

    always_ff @(posedge clk) begin
        if (rst) warn_q <= 1'b0;
        else     warn_q <= pf_below;
    end

    assign rst_n_out = !active;
    assign ce_out_n  = ce_in_n || !vcc_ok;
    assign pfail_n   = !warn_q;
endmodule

// File: rtl/sup_reset_wdog_chk.sv
module sup_reset_wdog_chk #(
    parameter int HOLD_TICKS  = 12,
    parameter int PULSE_TICKS = 6
) (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic vcc_ok,
    input logic ce_out_n,
    input logic pf_below,
    input logic pfail_n,
    input logic rst_n_out
);
    localparam int MINW = (HOLD_TICKS < PULSE_TICKS) ? HOLD_TICKS : PULSE_TICKS;

    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)                 low_run <= '0;
        else if (rst_n_out)      low_run <= '0;
        else if (low_run != '1)  low_run <= low_run + 16'd1;
    end

    // R1
    powerup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rst_n_out);

    // R2
    fault_forces_rst_chk: assert property (@(posedge clk) disable iff (rst)
        !vcc_ok |=> !rst_n_out);

    // R4
    min_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_out) |-> (low_run >= 16'(MINW)));

    // R9
    ce_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        !vcc_ok |-> ce_out_n);

    // R10
    warn_follow_chk: assert property (@(posedge clk) disable iff (rst)
        pf_below |=> !pfail_n);

    // R11
    frozen_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !rst_n_out) |=> !rst_n_out);
endmodule

bind sup_reset_wdog sup_reset_wdog_chk #(
    .HOLD_TICKS(HOLD_TICKS), .PULSE_TICKS(PULSE_TICKS)
) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .vcc_ok(vcc_ok), .ce_out_n(ce_out_n),
    .pf_below(pf_below), .pfail_n(pfail_n), .rst_n_out(rst_n_out)
);

// File: tb/test_sup_reset_wdog.sv
module test_sup_reset_wdog;
    localparam int HOLD  = 12;
    localparam int PULSE = 6;
    localparam int DEB   = 4;
    localparam int WDOG  = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic vcc_ok = 1'b1;
    logic btn_n = 1'b1;
    logic strobe = 1'b1;
    logic ce_in_n = 1'b1;
    logic pf_below = 1'b0;
    logic rst_n_out, ce_out_n, pfail_n;

    int checks = 0;
    int errors = 0;

    typedef struct { int width; string req; } exp_t;
    exp_t exp_q[$];
    exp_t e;
    bit   mon_en = 1'b0;
    int   run = 0;
    bit   strobe_en = 1'b0;
    int   ph = 0;

    always #2.5 clk = ~clk;

    sup_reset_wdog #(.HOLD_TICKS(HOLD), .PULSE_TICKS(PULSE), .DEB_TICKS(DEB),
                     .WDOG_TICKS(WDOG), .SYNC_STAGES(2)) i_sup_reset_wdog (
        .clk(clk), .rst(rst), .tick(tick), .vcc_ok(vcc_ok), .btn_n(btn_n),
        .strobe(strobe), .ce_in_n(ce_in_n), .pf_below(pf_below),
        .rst_n_out(rst_n_out), .ce_out_n(ce_out_n), .pfail_n(pfail_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic expect_pulse(input int w, input string req);
        exp_t x;
        x.width = w;
        x.req   = req;
        exp_q.push_back(x);
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && rst_n_out) break;
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R1/R3/R4/R7", "expected pulses left", exp_q.size(), 0);
    endtask

    task automatic quiet_window(input int n, input string req);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rst_n_out) lows++;
        end
        chk(lows == 0, req, "reset samples low in quiet window", lows, 0);
    endtask

    // background strobe: a falling edge every 8 cycles
    always @(negedge clk) begin
        if (strobe_en) begin
            ph = ph + 1;
            strobe = ph[2];
        end else begin
            ph = 0;
            strobe = 1'b1;
        end
    end

    // scoreboard monitor: pops one expected width per finished low pulse
    always @(negedge clk) begin
        #1;
        if (mon_en) begin
            if (!rst_n_out) run++;
            else if (run > 0) begin
                if (exp_q.size() == 0)
                    chk(1'b0, "R5/R6/R8", "unexpected reset pulse width", run, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(run == e.width, e.req, "reset pulse width", run, e.width);
                end
                run = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(rst_n_out == 1'b0, "R1", "rst_n_out during rst", rst_n_out, 0);
        chk(pfail_n == 1'b1, "R10", "pfail_n during rst", pfail_n, 1);
        expect_pulse(HOLD, "R1");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        mon_en = 1'b1;
        strobe_en = 1'b1;
        drain();

        // R8: strobing keeps reset released
        quiet_window(200, "R8");

        // R9: chip-enable passes through with supply good
        @(negedge clk); ce_in_n = 1'b0; #1;
        chk(ce_out_n == 1'b0, "R9", "ce_out_n follow low", ce_out_n, 0);
        @(negedge clk); ce_in_n = 1'b1; #1;
        chk(ce_out_n == 1'b1, "R9", "ce_out_n follow high", ce_out_n, 1);

        // R2/R3/R9: supply fault of 10 cycles
        expect_pulse(10 + HOLD, "R3");
        @(negedge clk); vcc_ok = 1'b0; ce_in_n = 1'b0; #1;
        chk(ce_out_n == 1'b1, "R9", "ce_out_n blocked in fault", ce_out_n, 1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(rst_n_out == 1'b0, "R2", "rst_n_out during fault", rst_n_out, 0);
        end
        vcc_ok = 1'b1; #1;
        chk(ce_out_n == 1'b0, "R9", "ce_out_n after fault", ce_out_n, 0);
        drain();
        ce_in_n = 1'b1;

        // R10: power-fail warning
        @(negedge clk); pf_below = 1'b1;
        @(negedge clk);
        chk(pfail_n == 1'b0, "R10", "pfail_n asserted", pfail_n, 0);
        pf_below = 1'b0;
        @(negedge clk);
        chk(pfail_n == 1'b1, "R10", "pfail_n released", pfail_n, 1);

        // R5: short glitch ignored
        @(negedge clk); btn_n = 1'b0;
        repeat (DEB - 1) @(negedge clk);
        btn_n = 1'b1;
        quiet_window(40, "R5");

        // R4: long press gives a single pulse
        expect_pulse(PULSE, "R4");
        btn_n = 1'b0;
        repeat (60) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "press pulses outstanding", exp_q.size(), 0);
        // R6: release ignored
        btn_n = 1'b1;
        quiet_window(40, "R6");

        // R11: tick freeze lengthens the pulse
        expect_pulse(PULSE + 5, "R11");
        btn_n = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!rst_n_out) break;
        end
        tick = 1'b0;
        repeat (5) @(negedge clk);
        tick = 1'b1;
        drain();
        btn_n = 1'b1;
        quiet_window(30, "R6");

        // R7: watchdog expiry without strobes
        expect_pulse(PULSE, "R7");
        expect_pulse(PULSE, "R7");
        @(negedge clk); strobe_en = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!rst_n_out) break;
        end
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rst_n_out) break;
        end
        begin
            int hi = 0;
            for (int i = 0; i < 200; i++) begin
                if (!rst_n_out) break;
                hi++;
                @(negedge clk);
            end
            chk(hi == WDOG, "R7", "high interval between expiries", hi, WDOG);
        end
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (rst_n_out) break;
        end
        strobe_en = 1'b1;
        drain();
        quiet_window(100, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule